// File: doc/BRIEF.md
# Windowed Per-Channel DMA Register Bank

This block is the software-facing register file of a twenty-channel DMA engine. A single narrow register window serves every channel: software first writes a channel number into a select register. Later accesses to the per-channel offsets then reach that channel's control word, descriptor ring base, ring length, event mask, event flags, poll setting and the read-only ring position. A global mask register with one bit per channel and a global control register sit outside the window.

The hardware side of the engine uses plain per-channel strobes. It can raise event flags, force a channel's enable off, report that a channel is still draining, and advance a channel's ring position. The bank drives one interrupt line per channel. It also exports each channel's enable, reset-in-progress flag, ring base, ring length and ring position to the descriptor and transfer logic, which is not part of this block.

The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is a combinational function of `bus_addr` and the current register contents, so it is valid in the same cycle. Word offsets: 0 global control, 1 channel select, 2 global interrupt mask, 3 channel control, 4 ring base, 5 ring length, 6 event mask, 7 event flags, 8 poll setting, 9 ring position.

Top module: `dmareg_bank`

## Requirements
- R1: Offsets 3 to 9 access only the channel whose number was last written to the select register (offset 1, readable back). A write there leaves all other channels unchanged.
- R2: Bit 0 of channel control (offset 3) is the channel enable and drives `ch_enable`. It reads as 1 while the enable is set or while that channel's `hw_busy` is high. A `hw_en_clr` pulse clears the enable, and it wins over a software write of 1 in the same cycle.
- R3: Writing 1 to bit 1 of channel control starts a channel reset. The bit and `ch_in_reset` read 1 for exactly 4 cycles after the write edge, then clear without any software action.
- R4: From the reset write edge until the reset ends, that channel's event flags and ring position are held at 0. Hardware events and ring steps in that window are dropped.
- R5: Event flags (offset 7) occupy bits 6:1. Bit n-1 of a channel's `hw_evt` slice sets flag bit n. Writing ones clears flags, so 0x7E clears all six. Bit 0 and bits 31:7 read 0. A flag raised by hardware in the same cycle that software clears it stays set.
- R6: `ch_irq[n]` is high when any event flag of channel n is set together with its event-mask bit (offset 6, same bit positions), and bit n of the global mask (offset 2) is set.
- R7: Ring length (offset 5) resets to 25. Each `hw_desc_step` pulse advances the ring position (offset 9, read-only), and the position wraps to 0 when it would reach the ring length.
- R8: Writing 1 to bit 0 of global control (offset 0) returns every register of the bank to its reset value at that edge. Global control always reads 0.
- R9: Offsets 10 to 15 read 0 and ignore writes. While the select value is 20 or more, offsets 3 to 9 read 0 and ignore writes.
- R10: Ring base (offset 4) and poll setting (offset 8) hold a full 32-bit value per channel. Ring base drives that channel's `ch_base` slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 4 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| hw_evt | input | 120 | Six event-set strobes per channel, channel n at [6n+5:6n] |
| hw_en_clr | input | 20 | Per-channel force-disable strobe |
| hw_busy | input | 20 | Per-channel still-draining flag |
| hw_desc_step | input | 20 | Per-channel ring position advance strobe |
| ch_enable | output | 20 | Per-channel enable |
| ch_in_reset | output | 20 | Per-channel reset in progress |
| ch_irq | output | 20 | Per-channel interrupt line |
| ch_base | output | 640 | Ring base per channel, channel n at [32n+31:32n] |
| ch_count | output | 160 | Ring length per channel, channel n at [8n+7:8n] |
| ch_desc_idx | output | 160 | Ring position per channel, channel n at [8n+7:8n] |

## Verification
Two pairs of functions can land on the same edge. The first is a software write-ones clear of the event flags together with a hardware event on one of those flags. The second is a software enable write together with a hardware force-disable. The bench provokes each by raising the hardware strobe in the very cycle that carries the bus write. It then judges the outcome by reading the flags back, which must keep the new event while every other flag is cleared, and by checking `ch_enable`, which must be 0. The bench also fires events and ring steps inside a channel reset and confirms through the bus that none of them survive.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  // Word offsets of the register window
  typedef enum logic [ADDR_W-1:0] {
    OFF_GCTL  = 4'd0,
    OFF_SEL   = 4'd1,
    OFF_GIEN  = 4'd2,
    OFF_CCTL  = 4'd3,
    OFF_BASE  = 4'd4,
    OFF_COUNT = 4'd5,
    OFF_IEN   = 4'd6,
    OFF_STAT  = 4'd7,
    OFF_POLL  = 4'd8,
    OFF_IDX   = 4'd9
  } reg_off_e;

  // Write strobes for one channel's windowed registers
  typedef struct packed {
    logic cctl;
    logic base;
    logic count;
    logic ien;
    logic stat;
    logic poll;
  } chan_wr_t;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int unsigned N_CHAN = 20,
  parameter int unsigned SEL_W  = 5
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SEL_W-1:0]  sel,
  output logic              sel_ok,
  output logic              gctl_wr,
  output logic              sel_wr,
  output logic              gien_wr,
  output chan_wr_t          cwr
);

  always_comb begin
    sel_ok     = (32'(sel) < N_CHAN);
    gctl_wr    = bus_wr && (bus_addr == OFF_GCTL);
    sel_wr     = bus_wr && (bus_addr == OFF_SEL);
    gien_wr    = bus_wr && (bus_addr == OFF_GIEN);
    cwr.cctl   = bus_wr && sel_ok && (bus_addr == OFF_CCTL);
    cwr.base   = bus_wr && sel_ok && (bus_addr == OFF_BASE);
    cwr.count  = bus_wr && sel_ok && (bus_addr == OFF_COUNT);
    cwr.ien    = bus_wr && sel_ok && (bus_addr == OFF_IEN);
    cwr.stat   = bus_wr && sel_ok && (bus_addr == OFF_STAT);
    cwr.poll   = bus_wr && sel_ok && (bus_addr == OFF_POLL);
  end

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DEF_COUNT = 25,
  parameter int unsigned RST_CYC   = 4,
  parameter int unsigned EVT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  chan_wr_t          wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_W-1:0]  hw_evt,
  input  logic              hw_en_clr,
  input  logic              hw_busy,
  input  logic              hw_step,
  input  logic              gien_bit,
  output logic              en,
  output logic              in_rst,
  output logic              irq,
  output logic [DATA_W-1:0] base,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  idx,
  output logic [EVT_W-1:0]  ien,
  output logic [EVT_W-1:0]  stat,
  output logic [DATA_W-1:0] poll,
  output logic [DATA_W-1:0] cctl_rd
);

  localparam int unsigned RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0]  rst_cnt;
  logic             rst_start;
  logic             quiet;
  logic [EVT_W-1:0] clr_mask;
  logic [CNT_W:0]   idx_inc;

  always_comb begin
    in_rst    = (rst_cnt != '0);
    rst_start = wr.cctl && wdata[1] && !in_rst;
    quiet     = in_rst || rst_start;
    clr_mask  = wr.stat ? wdata[EVT_W:1] : '0;
    idx_inc   = {1'b0, idx} + 1'b1;
    irq       = gien_bit && (|(stat & ien));
    cctl_rd   = DATA_W'({in_rst, en | hw_busy});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      en      <= 1'b0;
      rst_cnt <= '0;
      base    <= '0;
      count   <= CNT_W'(DEF_COUNT);
      idx     <= '0;
      ien     <= '0;
      stat    <= '0;
      poll    <= '0;
    end else begin
      // hardware force-disable has priority over a software set
      if (hw_en_clr)    en <= 1'b0;
      else if (wr.cctl) en <= wdata[0];

      if (in_rst)         rst_cnt <= rst_cnt - 1'b1;
      else if (rst_start) rst_cnt <= RC_W'(RST_CYC);

      if (wr.base)  base  <= wdata;
      if (wr.count) count <= wdata[CNT_W-1:0];
      if (wr.ien)   ien   <= wdata[EVT_W:1];
      if (wr.poll)  poll  <= wdata;

      // flags: held clear during reset, otherwise set beats clear
      if (quiet) stat <= '0;
      else       stat <= (stat & ~clr_mask) | hw_evt;

      if (quiet)        idx <= '0;
      else if (hw_step) idx <= (idx_inc >= {1'b0, count}) ? '0 : idx_inc[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
  import dmareg_pkg::*;
#(
  parameter int unsigned N_CHAN = 20,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned EVT_W  = 6
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [SEL_W-1:0]                    sel,
  input  logic                                sel_ok,
  input  logic [N_CHAN-1:0]                   gien,
  input  logic [N_CHAN-1:0][DATA_W-1:0]       cctl_rd,
  input  logic [N_CHAN-1:0][DATA_W-1:0]       base,
  input  logic [N_CHAN-1:0][DATA_W-1:0]       poll,
  input  logic [N_CHAN-1:0][CNT_W-1:0]        count,
  input  logic [N_CHAN-1:0][CNT_W-1:0]        idx,
  input  logic [N_CHAN-1:0][EVT_W-1:0]        ien,
  input  logic [N_CHAN-1:0][EVT_W-1:0]        stat,
  output logic [DATA_W-1:0]                   rdata
);

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_SEL:  rdata = DATA_W'(sel);
      OFF_GIEN: rdata = DATA_W'(gien);
      OFF_CCTL:  if (sel_ok) rdata = cctl_rd[sel];
      OFF_BASE:  if (sel_ok) rdata = base[sel];
      OFF_COUNT: if (sel_ok) rdata = DATA_W'(count[sel]);
      OFF_IEN:   if (sel_ok) rdata = DATA_W'({ien[sel], 1'b0});
      OFF_STAT:  if (sel_ok) rdata = DATA_W'({stat[sel], 1'b0});
      OFF_POLL:  if (sel_ok) rdata = poll[sel];
      OFF_IDX:   if (sel_ok) rdata = DATA_W'(idx[sel]);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int unsigned N_CHAN    = 20,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DEF_COUNT = 25,
  parameter int unsigned RST_CYC   = 4,
  parameter int unsigned EVT_W     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [3:0]                bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [N_CHAN*EVT_W-1:0]   hw_evt,
  input  logic [N_CHAN-1:0]         hw_en_clr,
  input  logic [N_CHAN-1:0]         hw_busy,
  input  logic [N_CHAN-1:0]         hw_desc_step,
  output logic [N_CHAN-1:0]         ch_enable,
  output logic [N_CHAN-1:0]         ch_in_reset,
  output logic [N_CHAN-1:0]         ch_irq,
  output logic [N_CHAN*32-1:0]      ch_base,
  output logic [N_CHAN*CNT_W-1:0]   ch_count,
  output logic [N_CHAN*CNT_W-1:0]   ch_desc_idx
);

  localparam int unsigned SEL_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1;

  logic [SEL_W-1:0]  sel_q;
  logic [N_CHAN-1:0] gien_q;
  logic              sel_ok, gctl_wr, sel_wr, gien_wr, soft_clr;
  chan_wr_t          cwr;

  logic [N_CHAN-1:0][DATA_W-1:0] r_cctl, r_base, r_poll;
  logic [N_CHAN-1:0][CNT_W-1:0]  r_count, r_idx;
  logic [N_CHAN-1:0][EVT_W-1:0]  r_ien, r_stat;

  dmareg_decode #(.N_CHAN(N_CHAN), .SEL_W(SEL_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .sel      (sel_q),
    .sel_ok   (sel_ok),
    .gctl_wr  (gctl_wr),
    .sel_wr   (sel_wr),
    .gien_wr  (gien_wr),
    .cwr      (cwr)
  );

  assign soft_clr = gctl_wr && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      sel_q  <= '0;
      gien_q <= '0;
    end else begin
      if (sel_wr)  sel_q  <= bus_wdata[SEL_W-1:0];
      if (gien_wr) gien_q <= bus_wdata[N_CHAN-1:0];
    end
  end

  for (genvar n = 0; n < N_CHAN; n++) begin : g_ch
    chan_wr_t cw_n;
    assign cw_n = (sel_q == SEL_W'(n)) ? cwr : '0;

    dmareg_chan #(
      .CNT_W(CNT_W), .DEF_COUNT(DEF_COUNT), .RST_CYC(RST_CYC), .EVT_W(EVT_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .wr        (cw_n),
      .wdata     (bus_wdata),
      .hw_evt    (hw_evt[n*EVT_W +: EVT_W]),
      .hw_en_clr (hw_en_clr[n]),
      .hw_busy   (hw_busy[n]),
      .hw_step   (hw_desc_step[n]),
      .gien_bit  (gien_q[n]),
      .en        (ch_enable[n]),
      .in_rst    (ch_in_reset[n]),
      .irq       (ch_irq[n]),
      .base      (r_base[n]),
      .count     (r_count[n]),
      .idx       (r_idx[n]),
      .ien       (r_ien[n]),
      .stat      (r_stat[n]),
      .poll      (r_poll[n]),
      .cctl_rd   (r_cctl[n])
    );

    assign ch_base[n*32 +: 32]        = r_base[n];
    assign ch_count[n*CNT_W +: CNT_W]  = r_count[n];
    assign ch_desc_idx[n*CNT_W +: CNT_W] = r_idx[n];
  end

  dmareg_rdmux #(
    .N_CHAN(N_CHAN), .SEL_W(SEL_W), .CNT_W(CNT_W), .EVT_W(EVT_W)
  ) u_rd (
    .addr    (bus_addr),
    .sel     (sel_q),
    .sel_ok  (sel_ok),
    .gien    (gien_q),
    .cctl_rd (r_cctl),
    .base    (r_base),
    .poll    (r_poll),
    .count   (r_count),
    .idx     (r_idx),
    .ien     (r_ien),
    .stat    (r_stat),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/dmareg_bank_chk.sv
module dmareg_bank_chk #(
  parameter int unsigned N_CHAN  = 20,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_CYC = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [3:0]              bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [N_CHAN-1:0]       hw_en_clr,
  input logic [N_CHAN-1:0]       ch_enable,
  input logic [N_CHAN-1:0]       ch_in_reset,
  input logic [N_CHAN-1:0]       ch_irq,
  input logic [N_CHAN*CNT_W-1:0] ch_desc_idx
);

  logic glob_q;

  always_ff @(posedge clk) begin
    if (!rst_n) glob_q <= 1'b0;
    else        glob_q <= bus_wr && (bus_addr == 4'd0) && bus_wdata[0];
  end

  // R9: offsets past the map read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 4'd9) |-> (bus_rdata == 32'd0));

  for (genvar i = 0; i < N_CHAN; i++) begin : g_c
    logic [7:0] run;

    always_ff @(posedge clk) begin
      if (!rst_n)              run <= '0;
      else if (ch_in_reset[i]) run <= (run == 8'hFF) ? run : run + 8'd1;
      else                     run <= '0;
    end

    // R2: hardware force-disable leaves the channel off
    p_hwclr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hw_en_clr[i] |=> !ch_enable[i]);

    // R3: a channel reset that ends on its own lasted exactly RST_CYC cycles
    p_reset_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ch_in_reset[i]) && !glob_q) |-> (run == 8'(RST_CYC)));

    // R4: no interrupt and a zero ring position while a channel is in reset
    p_reset_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_in_reset[i] |-> (!ch_irq[i] && (ch_desc_idx[i*CNT_W +: CNT_W] == '0)));
  end

endmodule

bind dmareg_bank dmareg_bank_chk #(
  .N_CHAN(N_CHAN), .CNT_W(CNT_W), .RST_CYC(RST_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .hw_en_clr   (hw_en_clr),
  .ch_enable   (ch_enable),
  .ch_in_reset (ch_in_reset),
  .ch_irq      (ch_irq),
  .ch_desc_idx (ch_desc_idx)
);

// File: tb/dmareg_bank_test.sv
module dmareg_bank_test;

  localparam int N  = 20;
  localparam int EV = 6;
  localparam int CW = 8;

  localparam logic [3:0] A_GCTL = 4'd0, A_SEL = 4'd1, A_GIEN = 4'd2, A_CCTL = 4'd3,
                         A_BASE = 4'd4, A_COUNT = 4'd5, A_IEN = 4'd6, A_STAT = 4'd7,
                         A_POLL = 4'd8, A_IDX = 4'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N*EV-1:0] hw_evt = '0;
  logic [N-1:0] hw_en_clr = '0, hw_busy = '0, hw_desc_step = '0;
  logic [N-1:0] ch_enable, ch_in_reset, ch_irq;
  logic [N*32-1:0] ch_base;
  logic [N*CW-1:0] ch_count, ch_desc_idx;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sbq[$];

  always #2 clk = ~clk;

  dmareg_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
    .hw_en_clr(hw_en_clr), .hw_busy(hw_busy), .hw_desc_step(hw_desc_step),
    .ch_enable(ch_enable), .ch_in_reset(ch_in_reset), .ch_irq(ch_irq),
    .ch_base(ch_base), .ch_count(ch_count), .ch_desc_idx(ch_desc_idx)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each queued expectation against the read port
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      chk(bus_rdata, it.exp, it.tag);
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic pulse_evt(input int ch, input int fbit);
    @(posedge clk); #1;
    hw_evt[ch*EV + fbit - 1] = 1'b1;
    @(posedge clk); #1;
    hw_evt = '0;
  endtask

  task automatic pulse_step(input int ch);
    @(posedge clk); #1;
    hw_desc_step[ch] = 1'b1;
    @(posedge clk); #1;
    hw_desc_step = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(A_SEL,   32'd0,  "R1 reset select");
    rd(A_COUNT, 32'd25, "R7 reset ring length");
    rd(A_CCTL,  32'd0,  "R2 reset control");
    rd(A_GIEN,  32'd0,  "R6 reset global mask");
    chk(32'(ch_irq), 32'd0, "R6 reset irq");
    chk(32'(ch_count[19*CW +: CW]), 32'd25, "R7 reset ring length port");

    // R1 / R10: windowed base and poll
    wr(A_SEL, 32'd3);  wr(A_BASE, 32'hA5A50000);
    wr(A_SEL, 32'd4);  wr(A_BASE, 32'h12345678); wr(A_POLL, 32'hDEADBEEF);
    wr(A_SEL, 32'd3);
    rd(A_BASE, 32'hA5A50000, "R1 ch3 base kept");
    rd(A_POLL, 32'd0,        "R1 ch3 poll untouched");
    rd(A_SEL,  32'd3,        "R1 select readback");
    chk(ch_base[3*32 +: 32], 32'hA5A50000, "R10 ch3 base port");
    wr(A_SEL, 32'd4);
    rd(A_POLL, 32'hDEADBEEF, "R10 ch4 poll");

    // R9: out-of-range select and unmapped offsets
    wr(A_SEL, 32'd20);
    wr(A_BASE, 32'h11112222);
    wr(A_CCTL, 32'd1);
    rd(A_BASE, 32'd0,  "R9 select 20 reads zero");
    rd(A_SEL,  32'd20, "R9 select value kept");
    chk(32'(ch_enable), 32'd0, "R9 select 20 write ignored");
    wr(4'd12, 32'hFFFFFFFF);
    rd(4'd12, 32'd0, "R9 unmapped offset");
    wr(A_SEL, 32'd4);
    rd(A_BASE, 32'h12345678, "R9 no alias into ch4");
    wr(A_SEL, 32'd19);
    rd(A_BASE, 32'd0, "R9 no alias into ch19");

    // R2: enable, busy readback, hardware clear
    wr(A_SEL, 32'd5);
    wr(A_CCTL, 32'd1);
    chk(32'(ch_enable[5]), 32'd1, "R2 enable set");
    rd(A_CCTL, 32'd1, "R2 enable readback");
    @(posedge clk); #1 hw_busy[5] = 1'b1;
    wr(A_CCTL, 32'd0);
    chk(32'(ch_enable[5]), 32'd0, "R2 enable cleared");
    rd(A_CCTL, 32'd1, "R2 busy holds bit");
    @(posedge clk); #1 hw_busy[5] = 1'b0;
    rd(A_CCTL, 32'd0, "R2 stopped reads zero");
    wr(A_CCTL, 32'd1);
    @(posedge clk); #1 hw_en_clr[5] = 1'b1;
    @(posedge clk); #1 hw_en_clr = '0;
    chk(32'(ch_enable[5]), 32'd0, "R2 hardware clear");
    // collision: software set and hardware clear on one edge
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = A_CCTL; bus_wdata = 32'd1; hw_en_clr[5] = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; hw_en_clr = '0;
    chk(32'(ch_enable[5]), 32'd0, "R2 hardware clear wins");

    // R5 / R6: flags, mask, interrupt
    wr(A_SEL, 32'd6);
    wr(A_IEN, 32'h08);
    wr(A_GIEN, 32'(1 << 6));
    pulse_evt(6, 3);
    rd(A_STAT, 32'h08, "R5 flag set");
    chk(32'(ch_irq), 32'(1 << 6), "R6 irq raised");
    wr(A_GIEN, 32'd0);
    chk(32'(ch_irq[6]), 32'd0, "R6 global mask gates");
    wr(A_GIEN, 32'(1 << 6));
    chk(32'(ch_irq[6]), 32'd1, "R6 irq back");
    wr(A_STAT, 32'h08);
    rd(A_STAT, 32'd0, "R5 write-one clear");
    chk(32'(ch_irq[6]), 32'd0, "R6 irq drops");
    pulse_evt(6, 5);
    chk(32'(ch_irq[6]), 32'd0, "R6 masked flag");
    wr(A_STAT, 32'hFFFFFF81);
    rd(A_STAT, 32'h20, "R5 non-flag bits no effect");
    // collision: clear-all and new event on one edge
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h7E; hw_evt[6*EV + 1] = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; hw_evt = '0;
    rd(A_STAT, 32'h04, "R5 set wins over clear");

    // R4 / R3: channel reset
    pulse_step(6); pulse_step(6); pulse_step(6);
    rd(A_IDX, 32'd3, "R7 ring position advances");
    wr(A_CCTL, 32'd2);
    chk(32'(ch_in_reset[6]), 32'd1, "R3 reset starts");
    hw_evt[6*EV + 2] = 1'b1; hw_desc_step[6] = 1'b1;
    @(posedge clk); #1;
    hw_evt = '0; hw_desc_step = '0;
    chk(32'(ch_irq[6]), 32'd0, "R4 event dropped in reset");
    chk(32'(ch_desc_idx[6*CW +: CW]), 32'd0, "R4 position held");
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(32'(ch_in_reset[6]), 32'd1, "R3 still in reset at cycle 3");
    @(posedge clk); #1;
    chk(32'(ch_in_reset[6]), 32'd0, "R3 self-cleared after 4");
    rd(A_CCTL, 32'd0, "R3 reset bit reads zero");
    rd(A_STAT, 32'd0, "R4 flags cleared");
    rd(A_IDX,  32'd0, "R4 position cleared");

    // R7: ring wrap
    wr(A_SEL, 32'd7);
    wr(A_COUNT, 32'd3);
    chk(32'(ch_count[7*CW +: CW]), 32'd3, "R7 length port");
    pulse_step(7); pulse_step(7); pulse_step(7);
    rd(A_IDX, 32'd0, "R7 wrap to zero");
    pulse_step(7); pulse_step(7);
    rd(A_IDX, 32'd2, "R7 after wrap");
    chk(32'(ch_desc_idx[7*CW +: CW]), 32'd2, "R7 position port");

    // R8: global reset
    wr(A_SEL, 32'd3);
    wr(A_GCTL, 32'd1);
    rd(A_GCTL, 32'd0, "R8 control reads zero");
    rd(A_SEL,  32'd0, "R8 select cleared");
    chk(ch_base[3*32 +: 32], 32'd0, "R8 base cleared");
    chk(32'(ch_count[7*CW +: CW]), 32'd25, "R8 length restored");
    rd(A_GIEN, 32'd0, "R8 global mask cleared");

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule